// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a real-time clock core. It keeps the year, month, day, hours, minutes and seconds as packed BCD bytes. A prescaler counts tick enables from a 32.768 kHz reference, and after a full second's worth of them the calendar moves forward by one second. The calendar handles each month's length and the leap years. Hours always run in 24-hour form. The clock runs only while the run bit in the control register is set.

Software reads and writes the time, the alarm, the control, status and interrupt-enable registers through a flat byte-wide register port. Reads are combinational and writes take effect at the clock edge. A busy flag in the status register goes high during the last tick period before each seconds update. Software should wait for it to drop, so that it reads or writes the time between two updates and never sees a torn value.

The alarm holds a complete date and time, including the year. It matches only when every field is equal. It is compared once, right after each update, and a match sets a sticky flag. Software clears the flag by writing a one to its bit. The interrupt output is the flag gated by its enable.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the time reads 00:00:00 on day 0x01, month 0x01, year 0x00. The control register, the status register, the interrupt-enable register and irq are all 0.
- R2: While control bit 0 (run) is 1, the seconds advance once for every PRESCALE accepted tick enables. While run is 0, tick enables change nothing. Status bit 1 mirrors run.
- R3: Seconds and minutes wrap from 0x59 to 0x00 and carry. Hours wrap from 0x23 to 0x00 and carry into the day.
- R4: The day wraps to 0x01 after the last day of the month. That is 0x30 for months 0x04, 0x06, 0x09 and 0x11, 0x28 or 0x29 for month 0x02, and 0x31 for the rest. February has 0x29 days when the two-digit year is divisible by 4, with year 0x00 counted as a leap year.
- R5: The month wraps from 0x12 to 0x01 and increments the year. The year wraps from 0x99 to 0x00.
- R6: Status bit 0 (busy) is 1 while run is set and the prescaler is within its final BUSY_TICKS tick periods before an update. It is 0 otherwise. With the defaults it is high only in the tick period that ends in the update.
- R7: A write to any time register (addresses 0x0 to 0x5 hold seconds, minutes, hours, day, month, year) is visible at once and restarts the prescaler from zero, so the next update needs a full PRESCALE tick enables.
- R8: The alarm registers sit at 0x8 to 0xD in the same field order. Status bit 2 (alarm flag) is set one clock after an update whose new time equals all six alarm fields. A time that differs in any single field, the year included, does not set it. Each update is compared only once.
- R9: Writing status with bit 2 set clears the alarm flag. Writing status with bit 2 clear leaves the flag unchanged. The busy and run bits of status are read-only.
- R10: irq is 1 exactly when the alarm flag is set and bit 0 of the interrupt-enable register (0xE) is 1.
- R11: The alarm registers, control bit 0 and interrupt-enable bit 0 read back what was written. Unused addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz reference period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Alarm interrupt, flag AND enable |

## Verification
A seconds update lands at the clock edge that samples the PRESCALE-th accepted tick enable. The new time is readable right after that edge. The alarm flag and irq change one edge later. Busy reflects the prescaler count held between edges. The bench drives every input on the falling edge and samples a short time after it. It reads the time straight after the updating edge and checks that the flag and irq are still low there. It then waits exactly one more edge and expects them high. Register writes are checked on the sample after the edge that took them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam int NUM_FIELDS = 6;
  localparam logic [3:0] ADDR_CTRL = 4'h6;
  localparam logic [3:0] ADDR_STAT = 4'h7;
  localparam logic [3:0] ADDR_IEN  = 4'hE;

  localparam int STAT_BUSY = 0;
  localparam int STAT_RUN  = 1;
  localparam int STAT_ALM  = 2;

  // Increment one packed BCD byte, 99 wraps to 00.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) begin
      r = (v[7:4] == 4'd9) ? 8'h00 : {v[7:4] + 4'd1, 4'd0};
    end else begin
      r = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  // 10*tens mod 4 equals 2*tens mod 4, so only bit 4 of the tens matters.
  function automatic logic bcd_leap(input logic [7:0] y);
    logic [1:0] r;
    r = y[1:0] + {y[4], 1'b0};
    return (r == 2'd0);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    logic [7:0] r;
    case (m)
      8'h02:                      r = bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] get_field(input rtc_time_t t, input logic [2:0] idx);
    logic [7:0] r;
    case (idx)
      3'd0:    r = t.sec;
      3'd1:    r = t.min;
      3'd2:    r = t.hour;
      3'd3:    r = t.day;
      3'd4:    r = t.month;
      3'd5:    r = t.year;
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic rtc_time_t set_field(input rtc_time_t t, input logic [2:0] idx,
                                          input logic [7:0] v);
    rtc_time_t r;
    r = t;
    case (idx)
      3'd0:    r.sec   = v;
      3'd1:    r.min   = v;
      3'd2:    r.hour  = v;
      3'd3:    r.day   = v;
      3'd4:    r.month = v;
      3'd5:    r.year  = v;
      default: r = t;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE   = 32768,
  parameter int BUSY_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic restart,
  output logic sec_pulse,
  output logic busy
);
  localparam int CW        = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam int LAST      = PRESCALE - 1;
  localparam int BUSY_FROM = (BUSY_TICKS >= PRESCALE) ? 0 : PRESCALE - BUSY_TICKS;

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last   = (cnt_q == CW'(LAST));
  assign sec_pulse = run && tick_en && at_last && !restart;
  assign busy      = run && (cnt_q >= CW'(BUSY_FROM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (run && tick_en) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  output rtc_time_t  now
);
  rtc_time_t cur_q;
  rtc_time_t adv;
  logic      c_sec, c_min, c_hour, c_day, c_mon;

  // Carry chain: each carry requires all lower fields at their limit.
  always_comb begin
    c_sec  = (cur_q.sec == 8'h59);
    c_min  = c_sec  && (cur_q.min == 8'h59);
    c_hour = c_min  && (cur_q.hour == 8'h23);
    c_day  = c_hour && (cur_q.day == last_day(cur_q.month, cur_q.year));
    c_mon  = c_day  && (cur_q.month == 8'h12);

    adv       = cur_q;
    adv.sec   = c_sec ? 8'h00 : bcd_inc(cur_q.sec);
    if (c_sec)  adv.min   = c_min  ? 8'h00 : bcd_inc(cur_q.min);
    if (c_min)  adv.hour  = c_hour ? 8'h00 : bcd_inc(cur_q.hour);
    if (c_hour) adv.day   = c_day  ? 8'h01 : bcd_inc(cur_q.day);
    if (c_day)  adv.month = c_mon  ? 8'h01 : bcd_inc(cur_q.month);
    if (c_mon)  adv.year  = bcd_inc(cur_q.year);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '{year: 8'h00, month: 8'h01, day: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};
    end else if (wr_en) begin
      cur_q <= set_field(cur_q, wr_idx, wr_data);
    end else if (step) begin
      cur_q <= adv;
    end
  end

  assign now = cur_q;

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rtc_time_t  now,
  input  logic       step,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic       clr,
  output rtc_time_t  alarm,
  output logic       flag
);
  rtc_time_t alm_q;
  logic      upd_q;
  logic      hit;
  logic      flag_q;

  // Compare once, in the cycle after the update, against the new time.
  assign hit = upd_q && (now == alm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q  <= '0;
      upd_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      upd_q <= step;
      if (wr_en) alm_q <= set_field(alm_q, wr_idx, wr_data);
      if (hit)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign alarm = alm_q;
  assign flag  = flag_q;

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_pkg::*;
#(
  parameter int PRESCALE   = 32768,
  parameter int BUSY_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       reg_wr,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam logic [2:0] LAST_IDX = 3'(NUM_FIELDS - 1);

  logic      run_q, ien_q;
  logic      sec_pulse, busy;
  logic      in_time, in_alarm;
  logic      time_wr, alarm_wr, stat_clr;
  logic      alm_flag;
  rtc_time_t now, alarm;

  assign in_time  = !reg_addr[3] && (reg_addr[2:0] <= LAST_IDX);
  assign in_alarm =  reg_addr[3] && (reg_addr[2:0] <= LAST_IDX);
  assign time_wr  = reg_wr && in_time;
  assign alarm_wr = reg_wr && in_alarm;
  assign stat_clr = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[STAT_ALM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CTRL) run_q <= reg_wdata[0];
      if (reg_addr == ADDR_IEN)  ien_q <= reg_wdata[0];
    end
  end

  rtc_prescaler #(.PRESCALE(PRESCALE), .BUSY_TICKS(BUSY_TICKS)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run_q),
    .restart(time_wr), .sec_pulse(sec_pulse), .busy(busy)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .step(sec_pulse), .wr_en(time_wr),
    .wr_idx(reg_addr[2:0]), .wr_data(reg_wdata), .now(now)
  );

  rtc_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .now(now), .step(sec_pulse), .wr_en(alarm_wr),
    .wr_idx(reg_addr[2:0]), .wr_data(reg_wdata), .clr(stat_clr),
    .alarm(alarm), .flag(alm_flag)
  );

  always_comb begin
    reg_rdata = 8'h00;
    if (in_time) begin
      reg_rdata = get_field(now, reg_addr[2:0]);
    end else if (in_alarm) begin
      reg_rdata = get_field(alarm, reg_addr[2:0]);
    end else if (reg_addr == ADDR_CTRL) begin
      reg_rdata = {7'd0, run_q};
    end else if (reg_addr == ADDR_STAT) begin
      reg_rdata[STAT_BUSY] = busy;
      reg_rdata[STAT_RUN]  = run_q;
      reg_rdata[STAT_ALM]  = alm_flag;
    end else if (reg_addr == ADDR_IEN) begin
      reg_rdata = {7'd0, ien_q};
    end
  end

  assign irq = alm_flag && ien_q;

endmodule

// File: rtl/bcd_calendar_rtc_chk.sv
module bcd_calendar_rtc_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      sec_pulse,
  input logic      busy,
  input logic      time_wr,
  input logic      run,
  input rtc_time_t now,
  input rtc_time_t alarm,
  input logic      flag
);

  AST_UPDATE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> busy); // R6

  AST_TIME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !time_wr) |=> $stable(now)); // R2

  AST_STOPPED_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sec_pulse); // R2

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !time_wr && now.sec == 8'h59) |=> (now.sec == 8'h00)); // R3

  AST_FLAG_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(sec_pulse, 2)); // R8

  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(now == alarm)); // R8

endmodule

bind bcd_calendar_rtc bcd_calendar_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .busy(busy),
  .time_wr(time_wr), .run(run_q), .now(now), .alarm(alarm), .flag(alm_flag)
);

// File: tb/test_bcd_calendar_rtc.sv
module test_bcd_calendar_rtc;
  localparam int PS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  int m_s, m_mi, m_h, m_d, m_mo, m_y;

  bcd_calendar_rtc #(.PRESCALE(PS), .BUSY_TICKS(1)) i_bcd_calendar_rtc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m_s++;
    if (m_s == 60) begin m_s = 0; m_mi++; end
    if (m_mi == 60) begin m_mi = 0; m_h++; end
    if (m_h == 24) begin m_h = 0; m_d++; end
    if (m_d > mdays(m_mo, m_y)) begin m_d = 1; m_mo++; end
    if (m_mo == 13) begin m_mo = 1; m_y++; end
    if (m_y == 100) m_y = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic one_second();
    for (int i = 0; i < PS; i++) tick();
  endtask

  task automatic load_time();
    wr(4'h0, to_bcd(m_s));  wr(4'h1, to_bcd(m_mi)); wr(4'h2, to_bcd(m_h));
    wr(4'h3, to_bcd(m_d));  wr(4'h4, to_bcd(m_mo)); wr(4'h5, to_bcd(m_y));
  endtask

  task automatic check_time(input string req);
    logic [7:0] v;
    rd(4'h0, v); chk({req, " sec"},   v, to_bcd(m_s));
    rd(4'h1, v); chk({req, " min"},   v, to_bcd(m_mi));
    rd(4'h2, v); chk({req, " hour"},  v, to_bcd(m_h));
    rd(4'h3, v); chk({req, " day"},   v, to_bcd(m_d));
    rd(4'h4, v); chk({req, " month"}, v, to_bcd(m_mo));
    rd(4'h5, v); chk({req, " year"},  v, to_bcd(m_y));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_time("R1");
    rd(ADDR(6), v); chk("R1 ctrl", v, 0);
    rd(ADDR(7), v); chk("R1 status", v, 0);
    rd(ADDR(14), v); chk("R1 ien", v, 0);
    chk("R1 irq", irq, 0);
    rd(ADDR(15), v); chk("R11 unused addr", v, 0);

    // R2 stopped: tick enables ignored
    for (int i = 0; i < 2 * PS; i++) tick();
    check_time("R2 stopped");
    rd(ADDR(7), v); chk("R6 busy while stopped", v[0], 0);

    // R2/R6 run: busy only in the last tick period
    wr(ADDR(6), 8'h01);
    rd(ADDR(6), v); chk("R11 ctrl readback", v, 1);
    rd(ADDR(7), v); chk("R2 run status", v[1], 1);
    for (int k = 0; k < PS; k++) begin
      rd(ADDR(7), v); chk("R6 busy window", v[0], (k == PS - 1) ? 1 : 0);
      check_time("R2 before update");
      tick();
    end
    model_step();
    check_time("R2 one second");
    rd(ADDR(7), v); chk("R6 busy after update", v[0], 0);

    // R7 time write restarts prescaler
    tick(); tick();
    m_s = 10;
    wr(4'h0, to_bcd(m_s));
    rd(4'h0, v); chk("R7 immediate", v, to_bcd(m_s));
    for (int i = 0; i < PS - 1; i++) tick();
    rd(4'h0, v); chk("R7 no early update", v, to_bcd(m_s));
    tick();
    model_step();
    rd(4'h0, v); chk("R7 full second", v, to_bcd(m_s));

    // R3 carry chain over a long run across leap day midnight
    m_s = 30; m_mi = 58; m_h = 23; m_d = 29; m_mo = 2; m_y = 24;
    load_time();
    for (int i = 0; i < 95; i++) begin
      one_second();
      model_step();
      check_time("R3 run");
    end

    // R4/R5 month end sweep over several years
    foreach (sweep_years[j]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        m_y = sweep_years[j]; m_mo = mo; m_d = mdays(mo, m_y);
        m_h = 23; m_mi = 59; m_s = 59;
        load_time();
        one_second();
        model_step();
        check_time((mo == 12) ? "R5 year wrap" : "R4 month end");
      end
    end

    // R4 day that is not the last day must not wrap
    m_y = 23; m_mo = 2; m_d = 28; m_h = 23; m_mi = 59; m_s = 59;
    m_y = 21; load_time(); one_second(); model_step(); check_time("R4 non leap");
    m_y = 24; m_d = 28; m_mo = 2; m_h = 23; m_mi = 59; m_s = 59;
    load_time(); one_second(); model_step(); check_time("R4 leap 28 to 29");

    // R8/R10/R11 alarm match
    wr(4'h8, 8'h08); wr(4'h9, 8'h06); wr(4'hA, 8'h05);
    wr(4'hB, 8'h04); wr(4'hC, 8'h03); wr(4'hD, 8'h31);
    rd(4'h8, v); chk("R11 alarm sec", v, 8'h08);
    rd(4'hB, v); chk("R11 alarm day", v, 8'h04);
    rd(4'hD, v); chk("R11 alarm year", v, 8'h31);
    wr(ADDR(14), 8'h01);
    rd(ADDR(14), v); chk("R11 ien readback", v, 1);
    m_y = 31; m_mo = 3; m_d = 4; m_h = 5; m_mi = 6; m_s = 7;
    load_time();
    one_second();
    rd(ADDR(7), v); chk("R8 flag not yet", v[2], 0);
    chk("R10 irq not yet", irq, 0);
    @(negedge clk);
    rd(ADDR(7), v); chk("R8 flag set", v[2], 1);
    chk("R10 irq set", irq, 1);
    wr(ADDR(7), 8'h03);
    rd(ADDR(7), v); chk("R9 write zero keeps flag", v[2], 1);
    wr(ADDR(7), 8'h04);
    rd(ADDR(7), v); chk("R9 clear", v[2], 0);
    chk("R10 irq cleared", irq, 0);
    one_second();
    @(negedge clk);
    rd(ADDR(7), v); chk("R8 once only", v[2], 0);

    // R10 enable gates irq
    wr(ADDR(14), 8'h00);
    m_s = 7; load_time();
    one_second();
    @(negedge clk);
    rd(ADDR(7), v); chk("R8 flag again", v[2], 1);
    chk("R10 irq masked", irq, 0);
    wr(ADDR(14), 8'h01);
    chk("R10 irq unmasked", irq, 1);
    wr(ADDR(7), 8'h04);

    // R8 full-field match: year differs
    wr(4'hD, 8'h32);
    m_s = 7; load_time();
    one_second();
    @(negedge clk);
    rd(ADDR(7), v); chk("R8 year mismatch", v[2], 0);
    chk("R10 irq idle", irq, 0);

    done = 1;
    summary();
    $finish;
  end

  int sweep_years[4] = '{23, 24, 0, 99};

  function automatic logic [3:0] ADDR(input int a);
    return 4'(a);
  endfunction

endmodule